// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block computes one memory address for each access cycle and advances its own index in that same cycle. It keeps four programmable registers: the index (the address used next), a signed step that is added after each access, and a base and a length that mark out a circular buffer. Each access registers the index that was current at the time as the output address. The index then moves on by the step.

Three addressing modes are available. In linear mode the index is free-running and wraps at 16 bits. In circular mode the index stays inside the window `[base, base+length-1]`. A stream of writes into that window therefore replaces the oldest sample with the newest, and no stored data is ever moved. In bit-reverse mode the low N bits of the emitted address appear in mirrored order, with N programmable. This produces the scrambled ordering that radix-2 FFT stages need, while the index itself keeps counting linearly.

Top module: `wrap_addr_gen`

## Requirements
- R1: An asynchronous active-low reset clears the index, step, base and length registers to zero, and clears `addr` and `addrValid`. The first access after reset emits address 0.
- R2: When `wrEn` is high, `wrData` is loaded into the register chosen by `wrSel` (0 index, 1 step, 2 base, 3 length) at the clock edge. A write alone never changes `addr` or `addrValid`.
- R3: An access (`access` high at an edge) sets `addrValid` high for exactly the following cycle. `addr` then shows the address formed from the index as it was before that access's update. Without an access, `addrValid` is low, `addr` holds its value and the index does not move.
- R4: In linear mode (`mode` 0) each access replaces the index with index + step modulo 2^16. The step is read as two's complement, so values from 0x8000 up move the index downward.
- R5: In circular mode (`mode` 1), the sum index + step is reduced by length when it is at or above base + length, and raised by length when it is below base. With the index inside the window and |step| < length, the index stays within `[base, base+length-1]`.
- R6: In bit-reverse mode (`mode` 2) the address is the index with its low N bits in reversed order (bit i moves to bit N-1-i) and its upper bits passed through unchanged. The index advances by the step with linear arithmetic.
- R7: `revBits` gives N. A value of 0 acts as N=1, and values above 16 act as N=16.
- R8: When an index write and an access fall on the same edge, the written value becomes the new index and the access's update is discarded. The address of that access is still taken from the old index.
- R9: `mode` value 3 behaves exactly as linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 index, 1 step, 2 base, 3 length |
| wrData | input | 16 | Value to write |
| mode | input | 2 | 0 linear, 1 circular, 2 bit-reverse, 3 linear |
| revBits | input | 5 | Number of low address bits to mirror in bit-reverse mode |
| access | input | 1 | Access strobe: emit an address and advance the index |
| addr | output | 16 | Registered address of the last access |
| addrValid | output | 1 | High in the cycle after an access |

## Verification
The bench builds the block at its default 16-bit width with a 5-bit reverse-count field. This lets it drive the index through the 0xFFFF to 0x0000 rollover and ask for a full 16-bit mirror. It can also set `revBits` to values from 17 to 31, which must saturate. The circular window is placed away from zero. Both positive and negative steps are driven across both of its edges, and a closed-form model follows a longer sweep. The bit-reverse tests cover a full 8-point FFT ordering and mirrors of 4, 8 and 16 bits over the same index.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_LIN  = 2'd0,
    MODE_CIRC = 2'd1,
    MODE_REV  = 2'd2,
    MODE_SPARE = 2'd3
  } agu_mode_e;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_STEP  = 2'd1,
    SEL_BASE  = 2'd2,
    SEL_LEN   = 2'd3
  } agu_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldIndex;
    logic ldStep;
    logic ldBase;
    logic ldLen;
    logic advance;
    logic capture;
    logic useCirc;
    logic useRev;
  } agu_ctrl_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [1:0] mode,
  input  logic       access,
  output agu_ctrl_t  ctrl
);

  agu_sel_e  selDec;
  agu_mode_e modeDec;

  assign selDec  = agu_sel_e'(wrSel);
  assign modeDec = agu_mode_e'(mode);

  always_comb begin
    ctrl = '0;
    if (wrEn) begin
      unique case (selDec)
        SEL_INDEX: ctrl.ldIndex = 1'b1;
        SEL_STEP:  ctrl.ldStep  = 1'b1;
        SEL_BASE:  ctrl.ldBase  = 1'b1;
        SEL_LEN:   ctrl.ldLen   = 1'b1;
        default:   ;
      endcase
    end
    ctrl.advance = access;
    ctrl.capture = access;
    // spare encoding falls through to linear arithmetic
    ctrl.useCirc = (modeDec == MODE_CIRC);
    ctrl.useRev  = (modeDec == MODE_REV);
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.ldIndex, ctrl.ldStep, ctrl.ldBase, ctrl.ldLen})) // R2
    else $error("more than one register load strobe");

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (!ctrl.useCirc && !ctrl.useRev)) // R9
    else $error("spare mode selected a non-linear path");

endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW = 16,
  parameter int NW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] idx,
  input  logic [NW-1:0] revBits,
  output logic [AW-1:0] revAddr
);

  logic [AW-1:0] mirFull;
  logic [NW-1:0] nEff;
  logic [NW-1:0] shAmt;
  logic [AW-1:0] mask;
  logic [AW-1:0] mirLow;

  // full-width mirror of the index
  for (genvar b = 0; b < AW; b++) begin : g_mirror
    assign mirFull[b] = idx[AW-1-b];
  end

  // clamp the requested count into 1..AW
  always_comb begin
    if (revBits == '0)
      nEff = NW'(1);
    else if (revBits > NW'(AW))
      nEff = NW'(AW);
    else
      nEff = revBits;
  end

  assign shAmt   = NW'(AW) - nEff;
  assign mirLow  = mirFull >> shAmt;
  assign mask    = {AW{1'b1}} >> shAmt;
  assign revAddr = (idx & ~mask) | (mirLow & mask);

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int NW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  agu_ctrl_t     ctrl,
  input  logic [AW-1:0] wrData,
  input  logic [NW-1:0] revBits,
  output logic [AW-1:0] addr,
  output logic          addrValid
);

  localparam int EW = AW + 2;

  logic [AW-1:0] idxQ, stepQ, baseQ, lenQ;
  logic [AW-1:0] idxNext, linNext, circNext, revAddr, addrNext, addrQ;
  logic          validQ;

  logic signed [EW-1:0] sumExt, limExt, baseExt, lenExt, wrapExt;

  // linear post-modify, wraps at the register width
  assign linNext = idxQ + stepQ;

  // circular post-modify in a widened signed space
  assign sumExt  = signed'({2'b00, idxQ}) + signed'({{2{stepQ[AW-1]}}, stepQ});
  assign baseExt = signed'({2'b00, baseQ});
  assign lenExt  = signed'({2'b00, lenQ});
  assign limExt  = baseExt + lenExt;

  always_comb begin
    if (sumExt >= limExt)
      wrapExt = sumExt - lenExt;
    else if (sumExt < baseExt)
      wrapExt = sumExt + lenExt;
    else
      wrapExt = sumExt;
  end
  assign circNext = wrapExt[AW-1:0];

  agu_bitrev #(.AW(AW), .NW(NW)) u_bitrev (
    .idx     (idxQ),
    .revBits (revBits),
    .revAddr (revAddr)
  );

  always_comb begin
    idxNext = idxQ;
    if (ctrl.ldIndex)
      idxNext = wrData;
    else if (ctrl.advance)
      idxNext = ctrl.useCirc ? circNext : linNext;
  end

  assign addrNext = ctrl.useRev ? revAddr : idxQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxQ   <= '0;
      stepQ  <= '0;
      baseQ  <= '0;
      lenQ   <= '0;
      addrQ  <= '0;
      validQ <= 1'b0;
    end else begin
      idxQ   <= idxNext;
      if (ctrl.ldStep) stepQ <= wrData;
      if (ctrl.ldBase) baseQ <= wrData;
      if (ctrl.ldLen)  lenQ  <= wrData;
      if (ctrl.capture) addrQ <= addrNext;
      validQ <= ctrl.capture;
    end
  end

  assign addr      = addrQ;
  assign addrValid = validQ;

  // window membership and step bound, for the wrap check
  logic inWin, stepFits;
  logic [AW-1:0] stepMag;
  assign inWin    = ({1'b0, idxQ} >= {1'b0, baseQ}) &&
                    ({1'b0, idxQ} <  ({1'b0, baseQ} + {1'b0, lenQ}));
  assign stepMag  = stepQ[AW-1] ? (~stepQ + 1'b1) : stepQ;
  assign stepFits = stepMag < lenQ;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ldIndex |=> (idxQ == $past(wrData))) // R8
    else $error("index write lost to access update");

  AST_CIRC_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.advance && ctrl.useCirc && !ctrl.ldIndex && !ctrl.ldBase &&
     !ctrl.ldLen && inWin && stepFits) |=> inWin) // R5
    else $error("circular index left its window");

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.capture |=> $stable(addrQ)) // R3
    else $error("address moved without an access");

  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.advance && !ctrl.ldIndex) |=> $stable(idxQ)) // R3
    else $error("index moved without access or write");

endmodule

// File: rtl/wrap_addr_gen.sv
module wrap_addr_gen
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int NW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic [AW-1:0] wrData,
  input  logic [1:0]    mode,
  input  logic [NW-1:0] revBits,
  input  logic          access,
  output logic [AW-1:0] addr,
  output logic          addrValid
);

  agu_ctrl_t ctrl;

  agu_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .mode   (mode),
    .access (access),
    .ctrl   (ctrl)
  );

  agu_datapath #(.AW(AW), .NW(NW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .wrData    (wrData),
    .revBits   (revBits),
    .addr      (addr),
    .addrValid (addrValid)
  );

  AST_VALID_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> addrValid) // R3
    else $error("no valid after access");

  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !addrValid) // R3
    else $error("valid without access");

endmodule

// File: tb/tb_wrap_addr_gen.sv
module tb_wrap_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  mode = '0;
  logic [4:0]  revBits = '0;
  logic        access = 1'b0;
  logic [15:0] addr;
  logic        addrValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  wrap_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .mode(mode), .revBits(revBits), .access(access),
    .addr(addr), .addrValid(addrValid)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [15:0] data;
    logic [1:0]  md;
    logic [4:0]  nrev;
    logic        acc;
    logic [15:0] expA;
    logic        expV;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VT [NV] = '{
    '{1'b0,2'd0,16'h0000,2'd0,5'd0 ,1'b0,16'h0000,1'b0,4'd1}, // R1 idle after reset
    '{1'b1,2'd1,16'h0003,2'd0,5'd0 ,1'b0,16'h0000,1'b0,4'd2}, // R2 step=3
    '{1'b1,2'd0,16'h0010,2'd0,5'd0 ,1'b0,16'h0000,1'b0,4'd2}, // R2 index=0x10, no output change
    '{1'b0,2'd0,16'h0000,2'd0,5'd0 ,1'b1,16'h0010,1'b1,4'd3}, // R3 first access
    '{1'b0,2'd0,16'h0000,2'd0,5'd0 ,1'b1,16'h0013,1'b1,4'd4}, // R4 +3
    '{1'b0,2'd0,16'h0000,2'd0,5'd0 ,1'b0,16'h0013,1'b0,4'd3}, // R3 hold when idle
    '{1'b1,2'd1,16'hFFFE,2'd0,5'd0 ,1'b0,16'h0013,1'b0,4'd2}, // R2 step=-2
    '{1'b0,2'd0,16'h0000,2'd0,5'd0 ,1'b1,16'h0016,1'b1,4'd3}, // R3 index kept while idle
    '{1'b0,2'd0,16'h0000,2'd0,5'd0 ,1'b1,16'h0014,1'b1,4'd4}, // R4 negative step
    '{1'b1,2'd0,16'hFFFF,2'd0,5'd0 ,1'b0,16'h0014,1'b0,4'd2}, // R2 index=0xFFFF
    '{1'b1,2'd1,16'h0002,2'd0,5'd0 ,1'b0,16'h0014,1'b0,4'd2}, // R2 step=2
    '{1'b0,2'd0,16'h0000,2'd0,5'd0 ,1'b1,16'hFFFF,1'b1,4'd4}, // R4
    '{1'b0,2'd0,16'h0000,2'd0,5'd0 ,1'b1,16'h0001,1'b1,4'd4}, // R4 wrap at 16 bits
    '{1'b1,2'd2,16'h0100,2'd1,5'd0 ,1'b0,16'h0001,1'b0,4'd2}, // R2 base=0x100
    '{1'b1,2'd3,16'h0005,2'd1,5'd0 ,1'b0,16'h0001,1'b0,4'd2}, // R2 length=5
    '{1'b1,2'd0,16'h0103,2'd1,5'd0 ,1'b0,16'h0001,1'b0,4'd2}, // R2 index=0x103
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0103,1'b1,4'd5}, // R5 -> 0x105 wraps to 0x100
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0100,1'b1,4'd5}, // R5 upper wrap seen
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0102,1'b1,4'd5}, // R5
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0104,1'b1,4'd5}, // R5 last slot
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0101,1'b1,4'd5}, // R5 0x106 -> 0x101
    '{1'b1,2'd1,16'hFFFD,2'd1,5'd0 ,1'b0,16'h0101,1'b0,4'd2}, // R2 step=-3
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0103,1'b1,4'd5}, // R5
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0100,1'b1,4'd5}, // R5 first slot
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0102,1'b1,4'd5}, // R5 lower wrap 0xFD -> 0x102
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0104,1'b1,4'd5}, // R5 0xFF -> 0x104
    '{1'b1,2'd0,16'h0100,2'd1,5'd0 ,1'b1,16'h0101,1'b1,4'd8}, // R8 write+access, old index out
    '{1'b0,2'd0,16'h0000,2'd1,5'd0 ,1'b1,16'h0100,1'b1,4'd8}, // R8 written value won
    '{1'b1,2'd0,16'h0104,2'd3,5'd0 ,1'b0,16'h0100,1'b0,4'd2}, // R2 index=0x104
    '{1'b1,2'd1,16'h0001,2'd3,5'd0 ,1'b0,16'h0100,1'b0,4'd2}, // R2 step=1
    '{1'b0,2'd0,16'h0000,2'd3,5'd0 ,1'b1,16'h0104,1'b1,4'd9}, // R9
    '{1'b0,2'd0,16'h0000,2'd3,5'd0 ,1'b1,16'h0105,1'b1,4'd9}, // R9 no circular wrap
    '{1'b1,2'd0,16'hAB01,2'd2,5'd4 ,1'b0,16'h0105,1'b0,4'd2}, // R2 index=0xAB01
    '{1'b0,2'd0,16'h0000,2'd2,5'd4 ,1'b1,16'hAB08,1'b1,4'd6}, // R6 N=4 0001->1000
    '{1'b0,2'd0,16'h0000,2'd2,5'd4 ,1'b1,16'hAB04,1'b1,4'd6}, // R6 N=4 0010->0100
    '{1'b0,2'd0,16'h0000,2'd2,5'd8 ,1'b1,16'hABC0,1'b1,4'd6}, // R6 N=8
    '{1'b0,2'd0,16'h0000,2'd2,5'd16,1'b1,16'h20D5,1'b1,4'd6}, // R6 N=16
    '{1'b0,2'd0,16'h0000,2'd2,5'd0 ,1'b1,16'hAB05,1'b1,4'd7}, // R7 N=0 acts as 1
    '{1'b0,2'd0,16'h0000,2'd2,5'd31,1'b1,16'h60D5,1'b1,4'd7}, // R7 N=31 acts as 16
    '{1'b0,2'd0,16'h0000,2'd2,5'd1 ,1'b1,16'hAB07,1'b1,4'd7}, // R7 N=1
    '{1'b0,2'd0,16'h0000,2'd2,5'd1 ,1'b0,16'hAB07,1'b0,4'd3}  // R3 hold
  };

  task automatic check(input string req, input logic [15:0] a, input logic [15:0] ea,
                       input logic v, input logic ev);
    nChecks++;
    if (a !== ea || v !== ev) begin
      nFails++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b", req, a, v, ea, ev);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] sel, input logic [15:0] d,
                       input logic [1:0] md, input logic [4:0] nr, input logic acc);
    wrEn = we; wrSel = sel; wrData = d; mode = md; revBits = nr; access = acc;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; access = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", addr, 16'h0000, addrValid, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].we, VT[i].sel, VT[i].data, VT[i].md, VT[i].nrev, VT[i].acc);
      check($sformatf("R%0d vec%0d", VT[i].req, i), addr, VT[i].expA,
            addrValid, VT[i].expV);
    end

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async clear", addr, 16'h0000, addrValid, 1'b0);
    rst_n = 1'b1;
    drive(1'b0, 2'd0, 16'h0, 2'd0, 5'd0, 1'b1);
    check("R1 index cleared", addr, 16'h0000, addrValid, 1'b1);
    drive(1'b0, 2'd0, 16'h0, 2'd0, 5'd0, 1'b1);
    check("R1 step cleared", addr, 16'h0000, addrValid, 1'b1);

    // R5 circular sweeps against an arithmetic model
    begin
      int e;
      drive(1'b1, 2'd2, 16'h0020, 2'd1, 5'd0, 1'b0);
      drive(1'b1, 2'd3, 16'h0007, 2'd1, 5'd0, 1'b0);
      drive(1'b1, 2'd1, 16'h0003, 2'd1, 5'd0, 1'b0);
      drive(1'b1, 2'd0, 16'h0022, 2'd1, 5'd0, 1'b0);
      e = 'h22;
      for (int k = 0; k < 20; k++) begin
        drive(1'b0, 2'd0, 16'h0, 2'd1, 5'd0, 1'b1);
        check("R5 sweep +3", addr, 16'(e), addrValid, 1'b1);
        e = e + 3;
        if (e >= 'h27) e = e - 7;
      end
      drive(1'b1, 2'd1, 16'hFFFC, 2'd1, 5'd0, 1'b0);
      for (int k = 0; k < 12; k++) begin
        drive(1'b0, 2'd0, 16'h0, 2'd1, 5'd0, 1'b1);
        check("R5 sweep -4", addr, 16'(e), addrValid, 1'b1);
        e = e - 4;
        if (e < 'h20) e = e + 7;
      end
    end

    // R6 eight-point FFT order
    begin
      logic [15:0] ord [8];
      ord = '{16'h0040,16'h0044,16'h0042,16'h0046,16'h0041,16'h0045,16'h0043,16'h0047};
      drive(1'b1, 2'd1, 16'h0001, 2'd2, 5'd3, 1'b0);
      drive(1'b1, 2'd0, 16'h0040, 2'd2, 5'd3, 1'b0);
      for (int k = 0; k < 8; k++) begin
        drive(1'b0, 2'd0, 16'h0, 2'd2, 5'd3, 1'b1);
        check("R6 fft8 order", addr, ord[k], addrValid, 1'b1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule